// File: doc/BRIEF.md
# PWM Fault Guard

This block protects a group of complementary PWM output pins. It watches six active-low external fault pins, a short-circuit check on every complementary pair, a comparator trip, an oscillator-stop flag and a software trip request. When an enabled source reports a fault, the block latches a sticky flag for that source. On the same clock edge it drops every output-enable line, which puts the driven pins into high impedance.

The outputs stay disabled until software clears every flag by writing ones to a clear mask, and until no enabled source still shows its fault condition. A separate software hold input can also force the outputs to high impedance without latching anything. An interrupt line is high while any enabled source has its flag set.

The source vector has a fixed bit order. Bits `0..N_PINS-1` are the external pins. The next `N_PAIRS` bits are the pair short checks. The top three bits are, in order, comparator, oscillator stop and software trip. With the defaults this places the pins at bits 0-5, the pairs at bits 6-8, the comparator at bit 9, the oscillator stop at bit 10 and the software trip at bit 11.

Top module: `pfg_fault_guard`

## Requirements
- R1: After a synchronous active-low reset, `fault_flags` is 0, `fault_irq` is 0 and every `pin_oe` bit is 1.
- R2: Each external fault pin passes through a two-flop synchroniser. When `pin_mode[i]` is 0 (low-level mode), a low on `ext_fault_n[i]` sets flag bit i on the third rising edge after the pin falls.
- R3: If `pwm_hi[p]` and `pwm_lo[p]` are both at the active level (1 with the default `ACTIVE_HIGH`) at a rising edge, flag bit `N_PINS+p` is set on that edge.
- R4: A high `cmp_trip`, `osc_stop` or `sw_trip` at a rising edge sets flag bit 9, 10 or 11 respectively (default widths) on that edge.
- R5: A source whose `src_en` bit is 0 never sets its flag. It also does not hold the outputs disabled.
- R6: Flags are sticky. An edge with `clr_valid` high clears the bits set in `clr_mask` and leaves the other bits as they are. If a source's fault is present on the same edge as its clear, the flag stays set.
- R7: On the edge where any flag becomes set, all `pin_oe` bits go to 0. They stay at 0 while any flag is set, and all bits always carry the same value.
- R8: `pin_oe` returns to all ones only on an edge where no flag is set and no enabled source condition is present. For an external pin, the condition is a synchronised low level, in either mode.
- R9: `sw_hiz` high at an edge drives `pin_oe` to 0 from that edge on, without setting any flag. The outputs return on the first edge after it falls.
- R10: `fault_irq` is 1 exactly when some flag is set whose `src_en` bit is also 1.
- R11: When `pin_mode[i]` is 1 (falling-edge mode), only a high-to-low transition of the synchronised pin sets flag i. If the pin is held low after the flag is cleared, the flag is not set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_fault_n | input | N_PINS | External fault pins, active low, asynchronous |
| pin_mode | input | N_PINS | Per pin: 0 = low level, 1 = falling edge |
| pwm_hi | input | N_PAIRS | Upper output of each complementary pair |
| pwm_lo | input | N_PAIRS | Lower output of each complementary pair |
| cmp_trip | input | 1 | Comparator detection, active high, synchronous |
| osc_stop | input | 1 | Oscillator-stop flag, active high, synchronous |
| sw_trip | input | 1 | Software shutdown request, latched |
| sw_hiz | input | 1 | Software output hold, not latched |
| src_en | input | NSRC | Per-source enable |
| clr_valid | input | 1 | Clear strobe |
| clr_mask | input | NSRC | Flags to clear when `clr_valid` is high |
| pin_oe | output | 2*N_PAIRS | Output enables, 1 = drive, 0 = high impedance |
| fault_flags | output | NSRC | Sticky per-source flags |
| fault_irq | output | 1 | Fault interrupt |

## Verification
The checker watches several properties on every cycle. It confirms that flags never drop without a clear, that disabled sources never raise a flag, and that a pair short with its enable set always latches. It also confirms that outputs are off whenever a flag is set or the software hold is high, and that all output enables stay uniform. Some behaviour can only be shown by the bench's scenarios: the three-edge latency of the synchroniser, the difference between edge and level mode when a pin is held low, set-over-clear arbitration, and the delayed return of the outputs after the fault condition ends.

// File: rtl/pfg_pkg.sv
// Shared definitions for the PWM fault guard.
// Assumes the source vector order: external pins, pair checks, comparator,
// oscillator stop, software trip.
package pfg_pkg;
    typedef enum logic {
        DET_LEVEL = 1'b0,
        DET_FALL  = 1'b1
    } det_mode_e;

    // Number of latched sources: pins, pairs, plus three single sources.
    function automatic int src_count(int pins, int pairs);
        return pins + pairs + 3;
    endfunction
endpackage

// File: rtl/pfg_pin_sync.sv
// Two-flop synchroniser for the active-low fault pins, plus a third stage
// that holds the previous synchronised value for edge detection.
// Assumes the pins idle high, so every stage resets to 1.
module pfg_pin_sync #(
    parameter int N_PINS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_raw,
    output logic [N_PINS-1:0] pin_sync,
    output logic [N_PINS-1:0] pin_prev
);
    logic [N_PINS-1:0] meta_q;

    // Purpose: move the pins into the clock domain and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '1;
            pin_sync <= '1;
            pin_prev <= '1;
        end else begin
            meta_q   <= pin_raw;
            pin_sync <= meta_q;
            pin_prev <= pin_sync;
        end
    end
endmodule

// File: rtl/pfg_event_gen.sv
// Builds two vectors per source: a one-cycle fault event that sets the
// flag, and a level condition that keeps the outputs disabled.
// Assumes the pair, comparator, oscillator and software inputs are
// already synchronous to clk.
module pfg_event_gen #(
    parameter int N_PINS      = 6,
    parameter int N_PAIRS     = 3,
    parameter bit ACTIVE_HIGH = 1'b1,
    localparam int NSRC       = pfg_pkg::src_count(N_PINS, N_PAIRS)
) (
    input  logic [N_PINS-1:0]  pin_sync,
    input  logic [N_PINS-1:0]  pin_prev,
    input  logic [N_PINS-1:0]  pin_mode,
    input  logic [N_PAIRS-1:0] pwm_hi,
    input  logic [N_PAIRS-1:0] pwm_lo,
    input  logic               cmp_trip,
    input  logic               osc_stop,
    input  logic               sw_trip,
    output logic [NSRC-1:0]    src_event,
    output logic [NSRC-1:0]    src_cond
);
    localparam int PAIR_BASE = N_PINS;
    localparam int CMP_IDX   = N_PINS + N_PAIRS;
    localparam int OSC_IDX   = CMP_IDX + 1;
    localparam int SW_IDX    = CMP_IDX + 2;
    localparam logic ACT_LVL = ACTIVE_HIGH;

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        logic is_low;
        logic fell;
        // Purpose: choose between low-level and falling-edge detection for one pin.
        always_comb begin
            is_low       = !pin_sync[i];
            fell         = pin_prev[i] && !pin_sync[i];
            src_cond[i]  = is_low;
            src_event[i] = (pin_mode[i] == pfg_pkg::DET_FALL) ? fell : is_low;
        end
    end

    for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
        logic both_on;
        // Purpose: flag a pair whose two outputs sit at the active level together.
        always_comb begin
            both_on                  = (pwm_hi[p] == ACT_LVL) && (pwm_lo[p] == ACT_LVL);
            src_cond[PAIR_BASE + p]  = both_on;
            src_event[PAIR_BASE + p] = both_on;
        end
    end

    // Purpose: pass the level-type single sources straight through.
    always_comb begin
        src_event[CMP_IDX] = cmp_trip;
        src_event[OSC_IDX] = osc_stop;
        src_event[SW_IDX]  = sw_trip;
        src_cond[CMP_IDX]  = cmp_trip;
        src_cond[OSC_IDX]  = osc_stop;
        src_cond[SW_IDX]   = sw_trip;
    end
endmodule

// File: rtl/pfg_flag_bank.sv
// Sticky per-source flags with write-one-to-clear and a registered shutdown
// state. Assumes set has priority over clear on the same edge.
module pfg_flag_bank #(
    parameter int NSRC = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_event,
    input  logic [NSRC-1:0] src_cond,
    input  logic [NSRC-1:0] src_en,
    input  logic            clr_valid,
    input  logic [NSRC-1:0] clr_mask,
    input  logic            sw_hiz,
    output logic [NSRC-1:0] flags,
    output logic            shut
);
    logic [NSRC-1:0] clr_eff;
    logic [NSRC-1:0] flags_d;
    logic            hold_cond;
    logic            shut_d;

    // Purpose: compute next flag values and the next shutdown state.
    always_comb begin
        clr_eff   = clr_valid ? clr_mask : '0;
        flags_d   = (flags & ~clr_eff) | (src_event & src_en);
        hold_cond = |(src_cond & src_en);
        shut_d    = (|flags_d) || hold_cond || sw_hiz;
    end

    // Purpose: hold the flags and the shutdown state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            shut  <= 1'b0;
        end else begin
            flags <= flags_d;
            shut  <= shut_d;
        end
    end
endmodule

// File: rtl/pfg_fault_guard.sv
// PWM fault guard top. Gathers the fault sources, latches them, and turns
// off the output enables of every complementary pair while any fault is
// pending or still present. Assumes a single clock domain except for the
// external fault pins.
module pfg_fault_guard #(
    parameter int N_PINS      = 6,
    parameter int N_PAIRS     = 3,
    parameter bit ACTIVE_HIGH = 1'b1,
    localparam int NSRC       = pfg_pkg::src_count(N_PINS, N_PAIRS),
    localparam int N_OE       = 2 * N_PAIRS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PINS-1:0]  ext_fault_n,
    input  logic [N_PINS-1:0]  pin_mode,
    input  logic [N_PAIRS-1:0] pwm_hi,
    input  logic [N_PAIRS-1:0] pwm_lo,
    input  logic               cmp_trip,
    input  logic               osc_stop,
    input  logic               sw_trip,
    input  logic               sw_hiz,
    input  logic [NSRC-1:0]    src_en,
    input  logic               clr_valid,
    input  logic [NSRC-1:0]    clr_mask,
    output logic [N_OE-1:0]    pin_oe,
    output logic [NSRC-1:0]    fault_flags,
    output logic               fault_irq
);
    logic [N_PINS-1:0] pin_sync;
    logic [N_PINS-1:0] pin_prev;
    logic [NSRC-1:0]   src_event;
    logic [NSRC-1:0]   src_cond;
    logic              shut;

    pfg_pin_sync #(.N_PINS(N_PINS)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (ext_fault_n),
        .pin_sync (pin_sync),
        .pin_prev (pin_prev)
    );

    pfg_event_gen #(
        .N_PINS      (N_PINS),
        .N_PAIRS     (N_PAIRS),
        .ACTIVE_HIGH (ACTIVE_HIGH)
    ) evt_i (
        .pin_sync  (pin_sync),
        .pin_prev  (pin_prev),
        .pin_mode  (pin_mode),
        .pwm_hi    (pwm_hi),
        .pwm_lo    (pwm_lo),
        .cmp_trip  (cmp_trip),
        .osc_stop  (osc_stop),
        .sw_trip   (sw_trip),
        .src_event (src_event),
        .src_cond  (src_cond)
    );

    pfg_flag_bank #(.NSRC(NSRC)) flag_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_event (src_event),
        .src_cond  (src_cond),
        .src_en    (src_en),
        .clr_valid (clr_valid),
        .clr_mask  (clr_mask),
        .sw_hiz    (sw_hiz),
        .flags     (fault_flags),
        .shut      (shut)
    );

    // Purpose: fan the shutdown state out to every enable and form the interrupt.
    always_comb begin
        pin_oe    = {N_OE{!shut}};
        fault_irq = |(fault_flags & src_en);
    end
endmodule

// File: rtl/pfg_fault_guard_chk.sv
// Checker for the PWM fault guard. It is attached to every instance of the
// top through the bind statement at the end of this file.
module pfg_fault_guard_chk #(
    parameter int N_PINS      = 6,
    parameter int N_PAIRS     = 3,
    parameter bit ACTIVE_HIGH = 1'b1,
    localparam int NSRC       = pfg_pkg::src_count(N_PINS, N_PAIRS),
    localparam int N_OE       = 2 * N_PAIRS
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_PAIRS-1:0] pwm_hi,
    input logic [N_PAIRS-1:0] pwm_lo,
    input logic               sw_hiz,
    input logic [NSRC-1:0]    src_en,
    input logic               clr_valid,
    input logic [NSRC-1:0]    clr_mask,
    input logic [N_OE-1:0]    pin_oe,
    input logic [NSRC-1:0]    fault_flags,
    input logic               fault_irq
);
    localparam logic ACT_LVL = ACTIVE_HIGH;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        // R6: a flag only falls when it is cleared.
        a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (fault_flags[i] && !(clr_valid && clr_mask[i])) |=> fault_flags[i]);
        // R5: a disabled source cannot raise its flag.
        a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (!fault_flags[i] && !src_en[i]) |=> !fault_flags[i]);
    end

    for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
        // R3: an enabled pair short always latches its flag.
        a_r3_short_latch: assert property (@(posedge clk) disable iff (!rst_n)
            (pwm_hi[p] == ACT_LVL && pwm_lo[p] == ACT_LVL && src_en[N_PINS + p])
            |=> fault_flags[N_PINS + p]);
    end

    // R7: outputs are off while any flag is set.
    a_r7_oe_off_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (|fault_flags) |-> (pin_oe == '0));

    // R7: all output enables move together.
    a_r7_oe_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe == '0) || (pin_oe == '1));

    // R9: the software hold turns the outputs off on the next edge.
    a_r9_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        sw_hiz |=> (pin_oe == '0));

    // R10: an interrupt always comes with disabled outputs.
    a_r10_irq_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        fault_irq |-> (pin_oe == '0));
endmodule

bind pfg_fault_guard pfg_fault_guard_chk #(
    .N_PINS      (N_PINS),
    .N_PAIRS     (N_PAIRS),
    .ACTIVE_HIGH (ACTIVE_HIGH)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwm_hi      (pwm_hi),
    .pwm_lo      (pwm_lo),
    .sw_hiz      (sw_hiz),
    .src_en      (src_en),
    .clr_valid   (clr_valid),
    .clr_mask    (clr_mask),
    .pin_oe      (pin_oe),
    .fault_flags (fault_flags),
    .fault_irq   (fault_irq)
);

// File: tb/pfg_fault_guard_tb.sv
module pfg_fault_guard_tb_top;
    localparam int NP   = 6;
    localparam int NQ   = 3;
    localparam int NS   = NP + NQ + 3;
    localparam int NOE  = 2 * NQ;
    localparam int NVEC = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] ext_fault_n;
    logic [NP-1:0] pin_mode;
    logic [NQ-1:0] pwm_hi, pwm_lo;
    logic          cmp_trip, osc_stop, sw_trip, sw_hiz;
    logic [NS-1:0] src_en;
    logic          clr_valid;
    logic [NS-1:0] clr_mask;
    logic [NOE-1:0] pin_oe;
    logic [NS-1:0] fault_flags;
    logic          fault_irq;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    // Vector fields: [20:18] hi, [17:15] lo, [14] cmp, [13] osc, [12] sw, [11:0] expected flags
    localparam logic [20:0] VEC [NVEC] = '{
        {3'b001, 3'b001, 3'b000, 12'h040},
        {3'b010, 3'b010, 3'b000, 12'h080},
        {3'b100, 3'b100, 3'b000, 12'h100},
        {3'b011, 3'b100, 3'b000, 12'h000},
        {3'b000, 3'b000, 3'b100, 12'h200},
        {3'b000, 3'b000, 3'b010, 12'h400},
        {3'b000, 3'b000, 3'b001, 12'h800},
        {3'b101, 3'b101, 3'b100, 12'h340}
    };

    always #5 clk = ~clk;

    pfg_fault_guard #(.N_PINS(NP), .N_PAIRS(NQ)) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_fault_n(ext_fault_n), .pin_mode(pin_mode),
        .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .cmp_trip(cmp_trip), .osc_stop(osc_stop),
        .sw_trip(sw_trip), .sw_hiz(sw_hiz), .src_en(src_en), .clr_valid(clr_valid),
        .clr_mask(clr_mask), .pin_oe(pin_oe), .fault_flags(fault_flags),
        .fault_irq(fault_irq)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        clr_valid = 1'b1;
        clr_mask  = '1;
        step();
        clr_valid = 1'b0;
        clr_mask  = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ext_fault_n = '1; pin_mode = '0; pwm_hi = '0; pwm_lo = '0;
        cmp_trip = 0; osc_stop = 0; sw_trip = 0; sw_hiz = 0; src_en = '1;
        clr_valid = 0; clr_mask = '0;
        repeat (3) step();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 flags", 32'(fault_flags), 0);
        chk("R1 oe", 32'(pin_oe), 32'h3F);
        chk("R1 irq", 32'(fault_irq), 0);

        // Table walk: R3 pair shorts, R4 single sources, R7 outputs off
        for (int v = 0; v < NVEC; v++) begin
            pwm_hi   = VEC[v][20:18];
            pwm_lo   = VEC[v][17:15];
            cmp_trip = VEC[v][14];
            osc_stop = VEC[v][13];
            sw_trip  = VEC[v][12];
            step();
            chk("R3/R4 flags", 32'(fault_flags), 32'(VEC[v][11:0]));
            chk("R7 oe", 32'(pin_oe), (VEC[v][11:0] == 0) ? 32'h3F : 0);
            pwm_hi = '0; pwm_lo = '0; cmp_trip = 0; osc_stop = 0; sw_trip = 0;
            clear_all();
            chk("R6 cleared", 32'(fault_flags), 0);
            chk("R8 oe back", 32'(pin_oe), 32'h3F);
        end

        // R2 level mode: flag on third edge
        ext_fault_n[2] = 1'b0;
        step(); chk("R2 edge1", 32'(fault_flags), 0);
        step(); chk("R2 edge2", 32'(fault_flags), 0);
        step(); chk("R2 edge3", 32'(fault_flags), 32'h004);
        chk("R7 oe pin", 32'(pin_oe), 0);
        // R6 set wins over clear while level still present
        clear_all();
        chk("R6 set wins", 32'(fault_flags), 32'h004);
        ext_fault_n[2] = 1'b1;
        repeat (3) step();
        clear_all();
        chk("R6 pin cleared", 32'(fault_flags), 0);
        chk("R8 oe pin", 32'(pin_oe), 32'h3F);

        // R11 edge mode with pin held low
        pin_mode[3] = 1'b1;
        ext_fault_n[3] = 1'b0;
        repeat (3) step();
        chk("R11 edge flag", 32'(fault_flags), 32'h008);
        clear_all();
        chk("R11 no reset", 32'(fault_flags), 0);
        chk("R8 held off", 32'(pin_oe), 0);
        step();
        chk("R11 still clear", 32'(fault_flags), 0);
        ext_fault_n[3] = 1'b1;
        step(); step();
        chk("R8 sync delay", 32'(pin_oe), 0);
        step();
        chk("R8 oe return", 32'(pin_oe), 32'h3F);

        // R6 partial clear
        cmp_trip = 1; osc_stop = 1;
        step();
        chk("R4 both", 32'(fault_flags), 32'h600);
        cmp_trip = 0; osc_stop = 0;
        clr_valid = 1; clr_mask = 12'h200;
        step();
        clr_valid = 0; clr_mask = '0;
        chk("R6 partial", 32'(fault_flags), 32'h400);
        clear_all();

        // R5 disabled source
        src_en[9] = 1'b0;
        cmp_trip = 1;
        step();
        chk("R5 no flag", 32'(fault_flags), 0);
        chk("R5 oe on", 32'(pin_oe), 32'h3F);
        chk("R5 irq", 32'(fault_irq), 0);
        cmp_trip = 0; src_en[9] = 1'b1;
        step();

        // R10 interrupt follows enable
        sw_trip = 1;
        step();
        sw_trip = 0;
        chk("R10 irq on", 32'(fault_irq), 1);
        src_en[11] = 1'b0;
        step();
        chk("R10 irq masked", 32'(fault_irq), 0);
        chk("R6 flag kept", 32'(fault_flags), 32'h800);
        chk("R7 oe off", 32'(pin_oe), 0);
        src_en[11] = 1'b1;
        clear_all();

        // R9 software hold
        sw_hiz = 1;
        step();
        chk("R9 oe off", 32'(pin_oe), 0);
        chk("R9 no flag", 32'(fault_flags), 0);
        sw_hiz = 0;
        step();
        chk("R9 oe back", 32'(pin_oe), 32'h3F);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule